// File: doc/BRIEF.md
# Column Line Latch with Polarity Steering

This block sits between a column loader and the per-column conversion stage of a display column driver. The loader fills a line buffer one beat at a time. A line strobe then copies the whole buffer into a holding latch. The latch presents one gray code per column. Alongside each code, the block gives a bank select that picks which of two reference banks the conversion stage uses. Odd-numbered and even-numbered columns always take opposite banks, and a polarity input decides which group takes the upper bank. This lets the panel run dot inversion without swinging the common electrode.

The line strobe also controls the output enables. While the strobe is high, every column output is held off (high impedance), so neighbouring columns can share charge. Outputs come back on once the strobe falls. The block sends a one-cycle clear to the loader after each strobe. A channel-count select, sampled with the strobe, keeps a fixed group of middle columns off for the narrower panel width. If a strobe arrives before the loader has reported a complete line, the block still latches whatever the buffer holds and sets a sticky short-line flag.

Top module: `llp_line_latch`

## Requirements
- R1: After reset, every column code is zero and every output enable is 0. The bank selects show the polarity-low assignment. The loader clear and the short-line flag are both 0.
- R2: At a clock edge where `strobe_i` is 1 after being 0 at the previous edge, the full `line_i` is copied to `code_o`. Column c occupies bits [c*CODE_W +: CODE_W], and the copy is visible right after that edge.
- R3: `line_i` has no effect on `code_o` at any edge other than a strobe rise.
- R4: `loader_clr_o` is 1 for exactly one cycle, the cycle that follows the edge that detected a strobe rise. It is 0 at all other times.
- R5: After any edge that samples `strobe_i` high, all `drive_en_o` bits are 0. After the edge that first samples `strobe_i` low again, the outputs are enabled (subject to R8), and they stay enabled until the next strobe.
- R6: `bank_hi_o[c]` = 1 selects the upper reference bank (references 9 to 16), and 0 selects the lower bank (references 1 to 8). Index c = 0 is column 1, which is odd. With the latched polarity at 1, odd-numbered columns (even c) get 1 and even-numbered columns get 0. With the latched polarity at 0, the assignment is the reverse.
- R7: `pol_i` is sampled only at a strobe rise. Changes to it at any other time leave `bank_hi_o` unchanged.
- R8: `narrow_i` is sampled at a strobe rise. When the sampled value is 1, columns GAP_FIRST to GAP_FIRST+GAP_LEN-1 (0-based) keep `drive_en_o` at 0 for the whole line. When it is 0, every column follows R5. Changes to `narrow_i` mid-line have no effect.
- R9: A strobe rise sampled while `line_done_i` is 0 sets `short_line_o` from the next cycle on. The flag stays set until reset. A rise with `line_done_i` at 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | COLS*CODE_W | Line buffer contents from the loader |
| line_done_i | input | 1 | Loader reports the line complete |
| strobe_i | input | 1 | Line strobe, synchronous level |
| pol_i | input | 1 | Polarity for the next line |
| narrow_i | input | 1 | 1 = reduced channel count (middle group disabled) |
| code_o | output | COLS*CODE_W | Latched per-column gray codes |
| bank_hi_o | output | COLS | Per-column bank select, 1 = upper bank |
| drive_en_o | output | COLS | Per-column output enable, 0 = high impedance |
| loader_clr_o | output | 1 | One-cycle clear of the loader fill position |
| short_line_o | output | 1 | Sticky: a strobe arrived before the line was complete |

## Verification
The properties assume that `strobe_i` is a clean synchronous level and that every strobe is held high for at least one clock edge. They also assume that the loader leaves at least four clocks of blanking between its last beat and the next line, so a strobe never rises on two edges back to back. The stimulus meets these assumptions in every case:
- It drives all inputs on the falling clock edge and samples results a short time after the rising edge.
- It holds each strobe high for two or more cycles.
- It leaves idle cycles between lines.

Within these limits, the bench deliberately changes `line_i`, `pol_i` and `narrow_i` while the strobe is high, so that only the values sampled at the rise can reach the outputs.

// File: rtl/llp_pkg.sv
package llp_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,  // after reset, nothing latched yet
    PH_SHARE = 2'd1,  // strobe high, outputs off for charge sharing
    PH_DRIVE = 2'd2   // outputs driven
  } phase_e;

  function automatic logic col_in_gap(input int col, input int first, input int len);
    return (col >= first) && (col < first + len);
  endfunction

endpackage

// File: rtl/llp_strobe_ctl.sv
module llp_strobe_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pol_i,
  input  logic narrow_i,
  input  logic line_done_i,
  output logic load_o,
  output logic pol_o,
  output logic narrow_o,
  output logic drive_o,
  output logic clr_o,
  output logic short_o
);
  import llp_pkg::*;

  logic   strobe_q;
  logic   rise;
  phase_e phase_q, phase_d;

  assign rise = strobe_i & ~strobe_q;

  always_comb begin
    phase_d = phase_q;
    if (strobe_i)                phase_d = PH_SHARE;
    else if (phase_q == PH_SHARE) phase_d = PH_DRIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      phase_q  <= PH_OFF;
      pol_o    <= 1'b0;
      narrow_o <= 1'b0;
      clr_o    <= 1'b0;
      short_o  <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      phase_q  <= phase_d;
      clr_o    <= rise;
      if (rise) begin
        pol_o    <= pol_i;
        narrow_o <= narrow_i;
        if (!line_done_i) short_o <= 1'b1;
      end
    end
  end

  assign load_o  = rise;
  assign drive_o = (phase_q == PH_DRIVE);

endmodule

// File: rtl/llp_hold_latch.sv
module llp_hold_latch #(
  parameter int COLS   = 24,
  parameter int CODE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [COLS*CODE_W-1:0] line_i,
  output logic [COLS*CODE_W-1:0] code_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     code_q <= '0;
      else if (load_i) code_q <= line_i[c*CODE_W +: CODE_W];
    end
    assign code_o[c*CODE_W +: CODE_W] = code_q;
  end

endmodule

// File: rtl/llp_col_steer.sv
module llp_col_steer #(
  parameter int COLS      = 24,
  parameter int GAP_FIRST = 12,
  parameter int GAP_LEN   = 3
) (
  input  logic            pol_i,
  input  logic            narrow_i,
  input  logic            drive_i,
  output logic [COLS-1:0] bank_hi_o,
  output logic [COLS-1:0] drive_en_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    // index 0 is column 1 (odd-numbered)
    if ((c % 2) == 0) begin : g_odd
      assign bank_hi_o[c] = pol_i;
    end else begin : g_even
      assign bank_hi_o[c] = ~pol_i;
    end
    if (llp_pkg::col_in_gap(c, GAP_FIRST, GAP_LEN)) begin : g_gap
      assign drive_en_o[c] = drive_i & ~narrow_i;
    end else begin : g_norm
      assign drive_en_o[c] = drive_i;
    end
  end

endmodule

// File: rtl/llp_line_latch.sv
module llp_line_latch #(
  parameter int COLS      = 24,
  parameter int CODE_W    = 8,
  parameter int GAP_FIRST = 12,
  parameter int GAP_LEN   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [COLS*CODE_W-1:0] line_i,
  input  logic                   line_done_i,
  input  logic                   strobe_i,
  input  logic                   pol_i,
  input  logic                   narrow_i,
  output logic [COLS*CODE_W-1:0] code_o,
  output logic [COLS-1:0]        bank_hi_o,
  output logic [COLS-1:0]        drive_en_o,
  output logic                   loader_clr_o,
  output logic                   short_line_o
);

  localparam int LINE_W = COLS * CODE_W;

  logic load, pol_q, narrow_q, drive;

  llp_strobe_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .pol_i       (pol_i),
    .narrow_i    (narrow_i),
    .line_done_i (line_done_i),
    .load_o      (load),
    .pol_o       (pol_q),
    .narrow_o    (narrow_q),
    .drive_o     (drive),
    .clr_o       (loader_clr_o),
    .short_o     (short_line_o)
  );

  logic [LINE_W-1:0] code;

  llp_hold_latch #(.COLS(COLS), .CODE_W(CODE_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .line_i (line_i),
    .code_o (code)
  );

  assign code_o = code;

  llp_col_steer #(.COLS(COLS), .GAP_FIRST(GAP_FIRST), .GAP_LEN(GAP_LEN)) u_steer (
    .pol_i      (pol_q),
    .narrow_i   (narrow_q),
    .drive_i    (drive),
    .bank_hi_o  (bank_hi_o),
    .drive_en_o (drive_en_o)
  );

endmodule

// File: rtl/llp_line_latch_chk.sv
module llp_line_latch_chk #(
  parameter int COLS      = 24,
  parameter int CODE_W    = 8,
  parameter int GAP_FIRST = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [COLS*CODE_W-1:0] line_i,
  input logic                   line_done_i,
  input logic                   strobe_i,
  input logic                   pol_i,
  input logic [COLS*CODE_W-1:0] code_o,
  input logic [COLS-1:0]        bank_hi_o,
  input logic [COLS-1:0]        drive_en_o,
  input logic                   loader_clr_o,
  input logic                   short_line_o
);

  logic prev_strobe;
  logic rise_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_strobe <= 1'b0;
    else         prev_strobe <= strobe_i;
  end

  assign rise_c = strobe_i & ~prev_strobe;

  AST_LATCH_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_c |=> code_o == $past(line_i)); // R2

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_c |=> $stable(code_o)); // R3

  AST_CLR_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_c |=> loader_clr_o); // R4

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_c |=> !loader_clr_o); // R4

  AST_OFF_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (drive_en_o == '0)); // R5

  AST_POL_SAMPLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_c |=> bank_hi_o[0] == $past(pol_i)); // R6

  AST_BANK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_c |=> $stable(bank_hi_o)); // R7

  AST_GAP_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o[GAP_FIRST] |-> drive_en_o[0]); // R8

  AST_SHORT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c && !line_done_i) |=> short_line_o); // R9

  AST_SHORT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_line_o |=> short_line_o); // R9

endmodule

bind llp_line_latch llp_line_latch_chk #(
  .COLS(COLS), .CODE_W(CODE_W), .GAP_FIRST(GAP_FIRST)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_i       (line_i),
  .line_done_i  (line_done_i),
  .strobe_i     (strobe_i),
  .pol_i        (pol_i),
  .code_o       (code_o),
  .bank_hi_o    (bank_hi_o),
  .drive_en_o   (drive_en_o),
  .loader_clr_o (loader_clr_o),
  .short_line_o (short_line_o)
);

// File: tb/llp_line_latch_test.sv
`timescale 1ns/1ps
module llp_line_latch_test;

  localparam int COLS      = 24;
  localparam int CODE_W    = 8;
  localparam int GAP_FIRST = 12;
  localparam int GAP_LEN   = 3;
  localparam int LW        = COLS * CODE_W;

  // {seed[7:0], pol, narrow, done}
  localparam logic [10:0] VEC [0:5] = '{
    {8'h11, 1'b1, 1'b0, 1'b1},
    {8'h5a, 1'b0, 1'b0, 1'b1},
    {8'hc3, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b0},
    {8'hff, 1'b1, 1'b0, 1'b1},
    {8'h3c, 1'b0, 1'b1, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [LW-1:0]   line_i = '0;
  logic            line_done_i = 1'b0;
  logic            strobe_i = 1'b0;
  logic            pol_i = 1'b0;
  logic            narrow_i = 1'b0;
  logic [LW-1:0]   code_o;
  logic [COLS-1:0] bank_hi_o;
  logic [COLS-1:0] drive_en_o;
  logic            loader_clr_o;
  logic            short_line_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  llp_line_latch #(.COLS(COLS), .CODE_W(CODE_W), .GAP_FIRST(GAP_FIRST), .GAP_LEN(GAP_LEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .line_done_i(line_done_i),
    .strobe_i(strobe_i), .pol_i(pol_i), .narrow_i(narrow_i), .code_o(code_o),
    .bank_hi_o(bank_hi_o), .drive_en_o(drive_en_o), .loader_clr_o(loader_clr_o),
    .short_line_o(short_line_o)
  );

  function automatic logic [LW-1:0] pat(input logic [7:0] seed);
    logic [LW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*CODE_W +: CODE_W] = seed ^ 8'(c * 29 + 7);
    return v;
  endfunction

  function automatic logic [COLS-1:0] exp_bank(input logic pol);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[c] = ((c % 2) == 0) ? pol : ~pol;
    return v;
  endfunction

  function automatic logic [COLS-1:0] exp_en(input logic narrow);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++)
      v[c] = !(narrow && c >= GAP_FIRST && c < GAP_FIRST + GAP_LEN);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_line(input logic [7:0] seed, input logic pol, input logic narrow,
                          input logic done, inout logic short_exp);
    logic [LW-1:0] ln;
    ln = pat(seed);
    @(negedge clk);
    line_i = ln; pol_i = pol; narrow_i = narrow; line_done_i = done; strobe_i = 1'b1;
    @(posedge clk); #1;
    if (!done) short_exp = 1'b1;
    chk(code_o == ln, "R2 latch on rise", code_o, ln);
    chk(loader_clr_o == 1'b1, "R4 clear pulse", LW'(loader_clr_o), LW'(1));
    chk(drive_en_o == '0, "R5 off during strobe", LW'(drive_en_o), '0);
    chk(bank_hi_o == exp_bank(pol), "R6 bank map", LW'(bank_hi_o), LW'(exp_bank(pol)));
    chk(short_line_o == short_exp, "R9 short flag", LW'(short_line_o), LW'(short_exp));
    @(negedge clk);
    line_i = ~ln; pol_i = ~pol; narrow_i = ~narrow; line_done_i = 1'b0;
    @(posedge clk); #1;
    chk(loader_clr_o == 1'b0, "R4 clear one cycle", LW'(loader_clr_o), '0);
    chk(code_o == ln, "R3 code held in strobe", code_o, ln);
    chk(drive_en_o == '0, "R5 still off", LW'(drive_en_o), '0);
    @(negedge clk);
    strobe_i = 1'b0;
    @(posedge clk); #1;
    chk(drive_en_o == exp_en(narrow), "R5 R8 drive after fall", LW'(drive_en_o), LW'(exp_en(narrow)));
    chk(bank_hi_o == exp_bank(pol), "R7 bank keeps sampled pol", LW'(bank_hi_o), LW'(exp_bank(pol)));
    chk(code_o == ln, "R3 code held after fall", code_o, ln);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(drive_en_o == exp_en(narrow), "R5 drive stays on", LW'(drive_en_o), LW'(exp_en(narrow)));
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic short_exp;
    logic [LW-1:0] last;
    short_exp = 1'b0;
    #5;
    @(negedge clk);
    // R1: reset state
    chk(code_o == '0, "R1 code zero", code_o, '0);
    chk(drive_en_o == '0, "R1 outputs off", LW'(drive_en_o), '0);
    chk(bank_hi_o == exp_bank(1'b0), "R1 bank pol low", LW'(bank_hi_o), LW'(exp_bank(1'b0)));
    chk(loader_clr_o == 1'b0 && short_line_o == 1'b0, "R1 clr and short low",
        LW'({loader_clr_o, short_line_o}), '0);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++)
      run_line(VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0], short_exp);

    // R3 R7 R8: idle input churn has no effect
    last = code_o;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      line_i = pat(8'(k * 17)); pol_i = ~pol_i; narrow_i = ~narrow_i;
    end
    @(posedge clk); #1;
    chk(code_o == last, "R3 idle line change ignored", code_o, last);
    chk(bank_hi_o == exp_bank(1'b0), "R7 idle pol change ignored", LW'(bank_hi_o), LW'(exp_bank(1'b0)));
    chk(drive_en_o == exp_en(1'b1), "R8 idle narrow change ignored", LW'(drive_en_o), LW'(exp_en(1'b1)));

    // R5: long strobe keeps outputs off every cycle
    @(negedge clk); strobe_i = 1'b1; line_done_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk(drive_en_o == '0, "R5 long strobe off", LW'(drive_en_o), '0);
    end
    @(negedge clk); strobe_i = 1'b0;
    for (int k = 0; k < 4; k++) @(negedge clk);

    // R9 R1: reset clears sticky flag
    chk(short_line_o == 1'b1, "R9 sticky before reset", LW'(short_line_o), LW'(1));
    rst_ni = 1'b0;
    #1;
    chk(short_line_o == 1'b0 && drive_en_o == '0 && code_o == '0, "R1 async reset clears",
        LW'({short_line_o, |drive_en_o, |code_o}), '0);
    @(negedge clk); rst_ni = 1'b1;
    short_exp = 1'b0;
    run_line(8'h99, 1'b1, 1'b0, 1'b1, short_exp);
    chk(short_line_o == 1'b0, "R9 complete line no flag", LW'(short_line_o), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule